// File: doc/BRIEF.md
# Carry-Free Effective Address Predictor

This unit sits beside the load/store address path of a processor and produces, for each memory access, a speculative data-cache address that is ready long before a full 32-bit add could finish. The set-index field of the prediction is the bitwise OR of the base and offset index fields. The block-offset field comes from a narrow true adder. The tag field comes from either a true adder or the same OR, and a parameter picks which one. The unit also forms the exact effective address, base plus offset, and raises a `pred_ok` flag only when the speculative address is guaranteed to match it.

The offset is either a signed 16-bit immediate, which is sign-extended, or a 32-bit register value, and an input flag selects between them. Misprediction is detected from four cause flags rather than from an address compare:
- a carry or borrow leaving the block-offset field;
- a carry generated inside the OR-formed field;
- a negative immediate that reaches outside the base address's cache block;
- any negative register offset.

When the immediate is negative, the bits of the offset above the block-offset field are inverted before they are combined. A small negative step inside a block then leaves the upper base bits unchanged. All outputs are registered, so results appear one clock after the inputs. The cache geometry defaults to 16 KiB direct-mapped with 16-byte blocks: block offset [3:0], index [13:4], tag [31:14].

Top module: `fac_predictor`

## Requirements
- R1: Every output is registered and reflects the inputs sampled at the previous rising clock edge. While synchronous active-high `rst` is high, every output is held at zero.
- R2: `true_addr_o` equals base plus offset modulo 2^32. The offset is `ofs_imm_i` sign-extended from bit 15 when `use_reg_i`=0, and `ofs_reg_i` when `use_reg_i`=1.
- R3: For a non-negative offset, the predicted index bits [13:4] are the bitwise OR of the base and offset index bits, and no carry enters or leaves that field.
- R4: The predicted block-offset bits [3:0] always equal the low four bits of the true sum.
- R5: For a negative immediate, every offset bit above bit 3 is inverted before the OR and tag stages. A negative immediate whose result stays in the base's block is therefore predicted correctly.
- R6: `fail_o[0]` (block overflow) is set when the 4-bit block add carries out for a non-negative or register offset, or does not carry out (a borrow) for a negative immediate.
- R7: `fail_o[1]` (generated carry) is set when base and prepared offset both hold a 1 at the same index bit. When `TAG_ADD`=0, a shared 1 at the same tag bit also sets it.
- R8: `fail_o[2]` (large negative constant) is set when `use_reg_i`=0, the immediate is negative, and its sign-extended bits [31:4] are not all ones.
- R9: `fail_o[3]` (negative register) is set whenever `use_reg_i`=1 and `ofs_reg_i[31]`=1.
- R10: `pred_ok_o` is high exactly when all four `fail_o` bits are zero. Whenever it is high, `pred_addr_o` equals `true_addr_o`.
- R11: With `TAG_ADD`=1 the predicted tag is the sum of the base and prepared tag fields. With `TAG_ADD`=0 it is their OR, so a tag overlap clears `pred_ok_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 32 | Base register value |
| ofs_imm_i | input | 16 | Signed immediate offset |
| ofs_reg_i | input | 32 | Register offset |
| use_reg_i | input | 1 | 1 selects the register offset, 0 the immediate |
| pred_addr_o | output | 32 | Speculative cache address |
| true_addr_o | output | 32 | Exact effective address |
| pred_ok_o | output | 1 | Speculative address is guaranteed correct |
| fail_o | output | 4 | Cause flags: [0] block overflow, [1] generated carry, [2] large negative constant, [3] negative register |

## Verification
The dangerous fault in this block is a missed cause flag. That fault shows as `pred_ok_o` high while `pred_addr_o` and `true_addr_o` differ, on the cycle right after the operands are applied. Directed vectors hit each cause flag alone and in combination. The vectors also cover in-block negative steps and tag overlap under both tag modes. A random sweep then checks the exact sum, the block-offset match and the guarantee on every cycle. A wrongly inverted or un-inverted offset shows at once as a wrong index field in `pred_addr_o` on an otherwise clean vector.

// File: rtl/fac_pkg.sv
package fac_pkg;
  // Misprediction cause flags; bit 0 is the block overflow.
  typedef struct packed {
    logic neg_reg;
    logic large_neg;
    logic gen_carry;
    logic overflow;
  } fac_fail_t;

  localparam int unsigned FAIL_W = 4;
endpackage

// File: rtl/fac_ofs_prep.sv
// Builds the true offset and the prepared offset used by the fast path.
module fac_ofs_prep #(
  parameter int unsigned AW       = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned BLK_BITS = 4
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AW-1:0]    reg_i,
  input  logic             use_reg_i,
  output logic [AW-1:0]    ofs_o,
  output logic [AW-1:0]    prep_o,
  output logic             neg_imm_o,
  output logic             neg_reg_o
);
  localparam int unsigned EXT_W = AW - IMM_W;
  localparam int unsigned UP_W  = AW - BLK_BITS;

  logic [AW-1:0] imm_ext;

  always_comb begin
    imm_ext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    neg_imm_o = !use_reg_i && imm_i[IMM_W-1];
    neg_reg_o = use_reg_i && reg_i[AW-1];
    ofs_o     = use_reg_i ? reg_i : imm_ext;
    prep_o    = ofs_o;
    // Inverting the upper bits turns an in-block negative step into zero there.
    if (neg_imm_o)
      prep_o[AW-1:BLK_BITS] = ~ofs_o[AW-1:BLK_BITS];
  end

  // R5
  always_comb begin
    ofs_prep_low_chk: assert (prep_o[BLK_BITS-1:0] == ofs_o[BLK_BITS-1:0]);
  end

  logic unused_ok;
  assign unused_ok = ^{UP_W{1'b0}};
endmodule

// File: rtl/fac_addr_form.sv
// Forms the speculative address: narrow block adder, OR-formed index,
// and a tag formed by an adder or an OR depending on TAG_ADD.
module fac_addr_form #(
  parameter int unsigned AW       = 32,
  parameter int unsigned BLK_BITS = 4,
  parameter int unsigned IDX_BITS = 10,
  parameter bit          TAG_ADD  = 1'b1
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] prep_i,
  output logic [AW-1:0] pred_o,
  output logic          blk_carry_o
);
  localparam int unsigned TAG_LO = BLK_BITS + IDX_BITS;
  localparam int unsigned TAG_W  = AW - TAG_LO;

  logic [BLK_BITS:0]   blk_sum;
  logic [IDX_BITS-1:0] idx_or;
  logic [TAG_W-1:0]    tag_val;

  assign blk_sum     = {1'b0, base_i[BLK_BITS-1:0]} + {1'b0, prep_i[BLK_BITS-1:0]};
  assign blk_carry_o = blk_sum[BLK_BITS];
  assign idx_or      = base_i[TAG_LO-1:BLK_BITS] | prep_i[TAG_LO-1:BLK_BITS];

  generate
    if (TAG_ADD) begin : g_tag_add
      assign tag_val = base_i[AW-1:TAG_LO] + prep_i[AW-1:TAG_LO];
    end else begin : g_tag_or
      assign tag_val = base_i[AW-1:TAG_LO] | prep_i[AW-1:TAG_LO];
    end
  endgenerate

  assign pred_o = {tag_val, idx_or, blk_sum[BLK_BITS-1:0]};
endmodule

// File: rtl/fac_fail_detect.sv
// Raises the four misprediction causes.
module fac_fail_detect
  import fac_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned BLK_BITS = 4,
  parameter int unsigned IDX_BITS = 10,
  parameter bit          TAG_ADD  = 1'b1
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ofs_i,
  input  logic [AW-1:0] prep_i,
  input  logic          neg_imm_i,
  input  logic          neg_reg_i,
  input  logic          blk_carry_i,
  output fac_fail_t     fail_o
);
  localparam int unsigned TAG_LO = BLK_BITS + IDX_BITS;

  logic idx_gen;
  logic tag_gen;

  assign idx_gen = |(base_i[TAG_LO-1:BLK_BITS] & prep_i[TAG_LO-1:BLK_BITS]);

  generate
    if (TAG_ADD) begin : g_tag_free
      assign tag_gen = 1'b0;
    end else begin : g_tag_check
      assign tag_gen = |(base_i[AW-1:TAG_LO] & prep_i[AW-1:TAG_LO]);
    end
  endgenerate

  always_comb begin
    fail_o.overflow  = neg_imm_i ? !blk_carry_i : blk_carry_i;
    fail_o.gen_carry = idx_gen || tag_gen;
    fail_o.large_neg = neg_imm_i && !(&ofs_i[AW-1:BLK_BITS]);
    fail_o.neg_reg   = neg_reg_i;
  end

  // R8
  always_comb begin
    large_neg_excl_chk: assert (!(neg_imm_i && neg_reg_i));
  end
endmodule

// File: rtl/fac_predictor.sv
// Top: registered speculative address, exact address and verdict.
module fac_predictor
  import fac_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned BLK_BITS = 4,
  parameter int unsigned IDX_BITS = 10,
  parameter bit          TAG_ADD  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     base_i,
  input  logic [IMM_W-1:0]  ofs_imm_i,
  input  logic [AW-1:0]     ofs_reg_i,
  input  logic              use_reg_i,
  output logic [AW-1:0]     pred_addr_o,
  output logic [AW-1:0]     true_addr_o,
  output logic              pred_ok_o,
  output logic [FAIL_W-1:0] fail_o
);
  logic [AW-1:0] ofs_full;
  logic [AW-1:0] ofs_prep;
  logic          neg_imm;
  logic          neg_reg;
  logic [AW-1:0] pred_c;
  logic          blk_carry;
  fac_fail_t     fail_c;
  logic [AW-1:0] true_c;

  fac_ofs_prep #(.AW(AW), .IMM_W(IMM_W), .BLK_BITS(BLK_BITS)) u_prep (
    .imm_i     (ofs_imm_i),
    .reg_i     (ofs_reg_i),
    .use_reg_i (use_reg_i),
    .ofs_o     (ofs_full),
    .prep_o    (ofs_prep),
    .neg_imm_o (neg_imm),
    .neg_reg_o (neg_reg)
  );

  fac_addr_form #(.AW(AW), .BLK_BITS(BLK_BITS), .IDX_BITS(IDX_BITS), .TAG_ADD(TAG_ADD)) u_form (
    .base_i      (base_i),
    .prep_i      (ofs_prep),
    .pred_o      (pred_c),
    .blk_carry_o (blk_carry)
  );

  fac_fail_detect #(.AW(AW), .BLK_BITS(BLK_BITS), .IDX_BITS(IDX_BITS), .TAG_ADD(TAG_ADD)) u_fail (
    .base_i      (base_i),
    .ofs_i       (ofs_full),
    .prep_i      (ofs_prep),
    .neg_imm_i   (neg_imm),
    .neg_reg_i   (neg_reg),
    .blk_carry_i (blk_carry),
    .fail_o      (fail_c)
  );

  assign true_c = base_i + ofs_full;

  logic primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_addr_o <= '0;
      true_addr_o <= '0;
      pred_ok_o   <= 1'b0;
      fail_o      <= '0;
      primed      <= 1'b0;
    end else begin
      pred_addr_o <= pred_c;
      true_addr_o <= true_c;
      pred_ok_o   <= (fail_c == '0);
      fail_o      <= fail_c;
      primed      <= 1'b1;
    end
  end

  // R10
  pred_match_chk: assert property (@(posedge clk) disable iff (rst)
    pred_ok_o |-> (pred_addr_o == true_addr_o));

  // R4
  blk_bits_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> (pred_addr_o[BLK_BITS-1:0] == true_addr_o[BLK_BITS-1:0]));

  // R9
  neg_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(use_reg_i && ofs_reg_i[AW-1])) |-> (fail_o[3] && !pred_ok_o));

  // R8
  large_neg_chk: assert property (@(posedge clk) disable iff (rst)
    fail_o[2] |-> !fail_o[3]);
endmodule

// File: tb/tb_fac_predictor.sv
`timescale 1ns/1ps
module tb_fac_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_i = '0;
  logic [15:0] ofs_imm_i = '0;
  logic [31:0] ofs_reg_i = '0;
  logic        use_reg_i = 1'b0;
  logic [31:0] pred_addr_o, true_addr_o, pred_or, true_or;
  logic        pred_ok_o, ok_or;
  logic [3:0]  fail_o, fail_or;

  always #2.5 clk = ~clk;

  fac_predictor dut (
    .clk(clk), .rst(rst), .base_i(base_i), .ofs_imm_i(ofs_imm_i),
    .ofs_reg_i(ofs_reg_i), .use_reg_i(use_reg_i),
    .pred_addr_o(pred_addr_o), .true_addr_o(true_addr_o),
    .pred_ok_o(pred_ok_o), .fail_o(fail_o)
  );

  fac_predictor #(.TAG_ADD(1'b0)) dut_or (
    .clk(clk), .rst(rst), .base_i(base_i), .ofs_imm_i(ofs_imm_i),
    .ofs_reg_i(ofs_reg_i), .use_reg_i(use_reg_i),
    .pred_addr_o(pred_or), .true_addr_o(true_or),
    .pred_ok_o(ok_or), .fail_o(fail_or)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {base, imm, reg, use_reg, expected fail flags}
  localparam int NV = 14;
  localparam logic [84:0] VEC [NV] = '{
    {32'h1000_0040, 16'h0000, 32'h0, 1'b0, 4'b0000}, // R3 zero offset
    {32'h1000_0040, 16'h0008, 32'h0, 1'b0, 4'b0000}, // R3 in-block
    {32'h0000_004C, 16'h0008, 32'h0, 1'b0, 4'b0001}, // R6 carry out
    {32'h0000_0040, 16'h0040, 32'h0, 1'b0, 4'b0010}, // R7 index overlap
    {32'h0000_0040, 16'h0010, 32'h0, 1'b0, 4'b0000}, // R3 disjoint index
    {32'h0000_0048, 16'hFFFC, 32'h0, 1'b0, 4'b0000}, // R5 small negative
    {32'h0000_0042, 16'hFFFC, 32'h0, 1'b0, 4'b0001}, // R6 borrow
    {32'h0000_0048, 16'hFFE0, 32'h0, 1'b0, 4'b0101}, // R8 large negative
    {32'h0000_0048, 16'h0000, 32'hFFFF_FFFC, 1'b1, 4'b1011}, // R9 negative reg
    {32'h2000_0000, 16'h0000, 32'h0000_0100, 1'b1, 4'b0000}, // R2 reg offset
    {32'h0000_4000, 16'h4000, 32'h0, 1'b0, 4'b0000}, // R11 tag add
    {32'h0000_0010, 16'h0000, 32'h7FFF_FFF0, 1'b1, 4'b0010}, // R7 reg overlap
    {32'h0001_0000, 16'h8000, 32'h0, 1'b0, 4'b0101}, // R8 most negative
    {32'hFFFF_FFF0, 16'h000F, 32'h0, 1'b0, 4'b0000}  // R4 top of space
  };

  function automatic logic [31:0] ref_sum(input logic [31:0] b, input logic [15:0] i,
                                          input logic [31:0] r, input logic u);
    return b + (u ? r : {{16{i[15]}}, i});
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared under reset
    repeat (3) @(negedge clk);
    base_i = 32'hFFFF_FFFF; ofs_imm_i = 16'h0001;
    @(negedge clk);
    check("R1 reset pred", pred_addr_o, 32'h0);
    check("R1 reset true", true_addr_o, 32'h0);
    check("R1 reset flags", {27'd0, pred_ok_o, fail_o}, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [31:0] s;
      @(negedge clk);
      base_i    = VEC[k][84:53];
      ofs_imm_i = VEC[k][52:37];
      ofs_reg_i = VEC[k][36:5];
      use_reg_i = VEC[k][4];
      s = ref_sum(base_i, ofs_imm_i, ofs_reg_i, use_reg_i);
      @(negedge clk);
      check("R2 true sum", true_addr_o, s);
      check("R6 R7 R8 R9 flags", {28'd0, fail_o}, {28'd0, VEC[k][3:0]});
      check("R10 ok", {31'd0, pred_ok_o}, {31'd0, VEC[k][3:0] == 4'b0});
      if (VEC[k][3:0] == 4'b0) check("R3 R5 pred", pred_addr_o, s);
      check("R4 block bits", {28'd0, pred_addr_o[3:0]}, {28'd0, s[3:0]});
    end

    // R11: tag overlap fails only in the OR-tag variant
    @(negedge clk);
    base_i = 32'h0000_4000; ofs_imm_i = 16'h4000; use_reg_i = 1'b0;
    @(negedge clk);
    check("R11 add tag pred", pred_addr_o, 32'h0000_8000);
    check("R11 or tag flags", {28'd0, fail_or}, 32'h2);
    check("R11 or tag ok", {31'd0, ok_or}, 32'h0);
    @(negedge clk);
    base_i = 32'h0000_4000; ofs_imm_i = 16'h0000; ofs_reg_i = 32'h0100_0000; use_reg_i = 1'b1;
    @(negedge clk);
    check("R11 or tag disjoint", pred_or, 32'h0100_4000);
    check("R11 or tag ok", {31'd0, ok_or}, 32'h1);

    // R1: a cycle of latency, reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", {pred_addr_o[0], pred_ok_o, fail_o}, 32'h0);
    rst = 1'b0;

    // Random sweep: exact sum, block match and the guarantee
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] s;
      @(negedge clk);
      base_i    = $urandom();
      if (n % 3 == 0) base_i = base_i & 32'hFFFF_C000;
      ofs_imm_i = (n % 2 == 0) ? 16'($urandom() % 64) : 16'($urandom());
      ofs_reg_i = (n % 4 == 0) ? ($urandom() % 256) : $urandom();
      use_reg_i = (n % 5 == 0);
      s = ref_sum(base_i, ofs_imm_i, ofs_reg_i, use_reg_i);
      @(negedge clk);
      check("R2 random sum", true_addr_o, s);
      check("R4 random block", {28'd0, pred_addr_o[3:0]}, {28'd0, s[3:0]});
      if (pred_ok_o) check("R10 random guarantee", pred_addr_o, s);
      if (ok_or) check("R11 random or guarantee", pred_or, s);
      check("R9 random negreg", {31'd0, fail_o[3]}, {31'd0, use_reg_i && ofs_reg_i[31]});
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule